// File: doc/BRIEF.md
# Thread-Interleaved Fetch Replay Controller

This controller feeds the fetch stage of a pipeline that interleaves several hardware threads. Each cycle it picks the next thread in a fixed rotation and presents that thread's program counter. A thread therefore never has more than one instruction in the pipeline, and the stages need no hazard logic between them.

Later stages report the outcome of each instruction. An instruction can be held back because a main-memory access is still pending, or because a deadline wait has not expired. When that happens, the thread's program counter stays where it is and the instruction is issued again on that thread's next turn, marked as a replay. The other threads and the rotation carry on without change. An instruction that completes moves its thread to the next sequential address, unless a branch or jump redirect for that thread supplies a new target.

Top module: `tfetch_replay`

## Requirements
- R1: During reset, and on the first cycle after it, the issuing thread is 0. Every thread's PC equals START_BASE + thread*START_STRIDE, and no thread is marked for replay.
- R2: The issuing thread ID rises by one on every clock edge and wraps from NT-1 back to 0. No input changes this order.
- R3: A completed result (res_valid=1, both stall bits 0) for thread t, with no redirect for t in the same cycle, advances t's PC by STEP bytes and clears t's replay flag.
- R4: A result for thread t with res_mem_stall=1 leaves t's PC unchanged. It also sets t's replay flag, so t's next issue shows the same PC with issue_replay=1.
- R5: A result for thread t with res_dl_stall=1 has the same effect as in R4.
- R6: A redirect (redir_valid=1) for thread t loads redir_target into t's PC and clears t's replay flag, even when no result for t is reported in that cycle.
- R7: When a stalled result and a redirect name the same thread in the same cycle, the stall takes precedence and the redirect is dropped.
- R8: A stall, result or redirect for one thread changes neither the PC nor the replay flag of any other thread.
- R9: When res_valid=0, res_tid and both stall bits are ignored.
- R10: A completed result and a redirect for the same thread in the same cycle load the redirect target, not the incremented PC.
- R11: A redirect for one thread and a result for another thread in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | An instruction outcome is reported this cycle |
| res_tid | input | TW | Thread that owns the reported outcome |
| res_mem_stall | input | 1 | The outcome is stalled on a pending main-memory access |
| res_dl_stall | input | 1 | The outcome is stalled on a deadline wait |
| redir_valid | input | 1 | A branch or jump redirect is reported this cycle |
| redir_tid | input | TW | Thread that the redirect applies to |
| redir_target | input | PCW | New PC for the redirected thread |
| issue_tid | output | TW | Thread issuing this cycle |
| issue_pc | output | PCW | PC of the issuing thread |
| issue_replay | output | 1 | The issued instruction repeats a stalled one |

## Verification
The issuing thread ID changes one edge after the previous one. A result or redirect sampled at an edge updates that thread's PC and replay flag at the same edge. The update becomes visible at the outputs the next time that thread holds the slot, which is between 1 and NT cycles later. The bench drives inputs on the falling edge and lets a single rising edge take them. On the following falling edge it compares issue_tid, issue_pc and issue_replay against a behavioural model of all thread states, so every delayed update is checked as soon as the thread issues again.

// File: rtl/tfetch_replay.sv
module tfetch_replay #(
  parameter int NT           = 6,
  parameter int PCW          = 32,
  parameter int STEP         = 4,
  parameter int START_BASE   = 32'h0000_1000,
  parameter int START_STRIDE = 32'h0000_0400,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           res_valid,
  input  logic [TW-1:0]  res_tid,
  input  logic           res_mem_stall,
  input  logic           res_dl_stall,
  input  logic           redir_valid,
  input  logic [TW-1:0]  redir_tid,
  input  logic [PCW-1:0] redir_target,
  output logic [TW-1:0]  issue_tid,
  output logic [PCW-1:0] issue_pc,
  output logic           issue_replay
);

  logic [TW-1:0]          slot;
  logic [NT-1:0][PCW-1:0] pc_q;
  logic [NT-1:0]          rep_q;

  always_ff @(posedge clk) begin
    if (rst || slot == TW'(NT - 1)) slot <= '0;
    else                            slot <= slot + 1'b1;
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    wire hit   = res_valid && res_tid == TW'(t);
    wire stall = hit && (res_mem_stall || res_dl_stall);
    wire jump  = redir_valid && redir_tid == TW'(t);

    always_ff @(posedge clk) begin
      if (rst) begin
        pc_q[t]  <= PCW'(START_BASE + START_STRIDE * t);
        rep_q[t] <= 1'b0;
      end else if (stall) begin
        rep_q[t] <= 1'b1;
      end else if (jump) begin
        pc_q[t]  <= redir_target;
        rep_q[t] <= 1'b0;
      end else if (hit) begin
        pc_q[t]  <= pc_q[t] + PCW'(STEP);
        rep_q[t] <= 1'b0;
      end
    end
  end

  assign issue_tid    = slot;
  assign issue_pc     = pc_q[slot];
  assign issue_replay = rep_q[slot];

endmodule

module tfetch_replay_chk #(
  parameter int NT = 6,
  parameter int PCW = 32,
  parameter int STEP = 4,
  parameter int START_BASE = 0,
  parameter int TW = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   res_valid,
  input logic [TW-1:0]          res_tid,
  input logic                   res_mem_stall,
  input logic                   res_dl_stall,
  input logic                   redir_valid,
  input logic [TW-1:0]          redir_tid,
  input logic [PCW-1:0]         redir_target,
  input logic [TW-1:0]          issue_tid,
  input logic [PCW-1:0]         issue_pc,
  input logic                   issue_replay,
  input logic [NT-1:0][PCW-1:0] pc_q,
  input logic [NT-1:0]          rep_q
);

  wire stalled = res_valid && (res_mem_stall || res_dl_stall);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> issue_tid == '0 && issue_pc == PCW'(START_BASE) && !issue_replay);

  // R2
  rotate_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> issue_tid == (($past(issue_tid) == TW'(NT - 1)) ? '0 : $past(issue_tid) + 1'b1));

  // R2
  tid_range_chk: assert property (@(posedge clk) disable iff (rst) issue_tid < TW'(NT));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stalled |=> rep_q[$past(res_tid)] && pc_q[$past(res_tid)] == $past(pc_q[res_tid]));

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_mem_stall && !res_dl_stall && !(redir_valid && redir_tid == res_tid)
    |=> !rep_q[$past(res_tid)] && pc_q[$past(res_tid)] == $past(pc_q[res_tid]) + PCW'(STEP));

  // R6
  redirect_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid && !(stalled && res_tid == redir_tid)
    |=> pc_q[$past(redir_tid)] == $past(redir_target) && !rep_q[$past(redir_tid)]);

endmodule

bind tfetch_replay tfetch_replay_chk #(
  .NT(NT), .PCW(PCW), .STEP(STEP), .START_BASE(START_BASE), .TW(TW)
) u_chk (.*);

// File: tb/sim_tfetch_replay.sv
module sim_tfetch_replay;
  localparam int PERIOD = 10;
  localparam int NT = 6;
  localparam int TW = 3;
  localparam int BASE = 32'h0000_1000;
  localparam int STRIDE = 32'h0000_0400;

  logic clk = 0, rst = 1;
  logic res_valid = 0, res_mem_stall = 0, res_dl_stall = 0, redir_valid = 0;
  logic [TW-1:0] res_tid = 0, redir_tid = 0;
  logic [31:0] redir_target = 0;
  logic [TW-1:0] issue_tid;
  logic [31:0] issue_pc;
  logic issue_replay;

  int vectors = 0, errors = 0;
  int mslot;
  logic [31:0] mpc [NT];
  bit mrep [NT];

  always #(PERIOD/2) clk = ~clk;

  tfetch_replay u0 (.*);

  always @(posedge clk) begin
    if (rst) begin
      mslot = 0;
      for (int t = 0; t < NT; t++) begin mpc[t] = BASE + STRIDE * t; mrep[t] = 0; end
    end else begin
      mslot = (mslot + 1) % NT;
      for (int t = 0; t < NT; t++) begin
        bit hit, st, jp;
        hit = res_valid && int'(res_tid) == t;
        st  = hit && (res_mem_stall || res_dl_stall);
        jp  = redir_valid && int'(redir_tid) == t;
        if (st) mrep[t] = 1;
        else if (jp) begin mpc[t] = redir_target; mrep[t] = 0; end
        else if (hit) begin mpc[t] = mpc[t] + 4; mrep[t] = 0; end
      end
    end
  end

  task automatic chk(string tag);
    vectors++;
    if (int'(issue_tid) != mslot || issue_pc !== mpc[mslot] || issue_replay !== mrep[mslot]) begin
      errors++;
      $display("FAIL %s: tid/pc/replay got %0d/%h/%b expected %0d/%h/%b", tag,
               issue_tid, issue_pc, issue_replay, mslot, mpc[mslot], mrep[mslot]);
    end
  endtask

  task automatic step(bit rv, int rt, bit ms, bit ds, bit dv, int dt, logic [31:0] tg, string tag);
    res_valid = rv; res_tid = TW'(rt); res_mem_stall = ms; res_dl_stall = ds;
    redir_valid = dv; redir_tid = TW'(dt); redir_target = tg;
    @(posedge clk); @(negedge clk);
    chk(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1");
    rst = 0;
    chk("R1");
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 12; i++) step(0, i % NT, 1, 1, 0, 0, 0, "R9");
    for (int i = 0; i < 18; i++) step(1, int'(issue_tid), 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 24; i++)
      step(1, int'(issue_tid), int'(issue_tid) == 2, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 24; i++)
      step(1, int'(issue_tid), 0, int'(issue_tid) == 5, 0, 0, 0, "R5");
    for (int i = 0; i < 12; i++) step(1, int'(issue_tid), 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 1, 32'h0000_8000, "R6");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 3, 1, 0, 1, 3, 32'h0000_9000, "R7");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 4, 0, 0, 1, 4, 32'h0000_A000, "R10");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 2, 0, 0, 1, 0, 32'h0000_B000, "R11");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 1), $urandom_range(0, NT - 1), $urandom_range(0, 2) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, NT - 1),
           $urandom & 32'hFFFF_FFFC, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule